// File: doc/BRIEF.md
# Logic Analyzer Host Command Decoder

This block sits between a UART byte receiver and the control registers of a small logic-analyzer core. It takes in host bytes through a ready/valid handshake and groups them into commands. The value of the opcode alone sets the length of a command. An opcode with bit 7 clear is a complete one-byte command. An opcode with bit 7 set is followed by a 32-bit argument sent low byte first. From these commands the block loads the trigger-stage mask, value and configuration words, the sample-clock divider, the capture read and delay counts, and the capture flag word. It also produces arm and reset events.

An identify command causes the block to return a four-byte signature through a byte-wide transmit handshake. The receive side is stalled until that reply has gone out. A zero byte seen where an opcode is expected acts as a reset. Because of this, a burst of five zero bytes puts the framing back in step from any position inside a command. Each long command, whether known or not, also appears on a one-cycle write strobe that carries its opcode and argument, so neighbouring logic can snoop it.

Top module: `la_cmd_decoder`

## Requirements
- R1: An accepted byte with bit 7 clear, arriving while an opcode is awaited, is a short command and takes effect on its own. An opcode with bit 7 set takes the next four accepted bytes as its argument, and only then takes effect.
- R2: Each completed long command raises `wr_strobe_o` for exactly one cycle, in the cycle after its fourth argument byte is accepted. During that cycle `wr_opcode_o` carries the opcode and `wr_arg_o` carries the argument, with the first argument byte in bits 7:0 and the last in bits 31:24.
- R3: Opcode 0x00 pulses `reset_o` for one cycle. It clears every trigger mask, value and configuration word, the flag word and the armed state. The divider and the capture counts keep their values. Five consecutive 0x00 bytes end in a reset from any framing position.
- R4: Opcode 0x02 sends the bytes 0x31, 0x53, 0x4C, 0x4F on `tx_data_o`, in that order, one per `tx_valid_o`/`tx_ready_i` handshake. `rx_ready_o` stays low until the last of these bytes has been taken.
- R5: Opcode 0x01 sets `armed_o`, which stays high until a reset.
- R6: For trigger stage n below STAGES, opcode 0xC0+4n loads the mask word, 0xC1+4n loads the value word and 0xC2+4n loads the configuration word. Each word goes to bits 32n+31:32n of its output.
- R7: `trig_start_o[n]` follows bit 27 (bit 3 of argument byte 3) of stage n's configuration word. Argument byte 2 holds the stage number and is stored unchanged in bits 23:16.
- R8: Opcode 0x80 loads `divider_o` from argument bytes 0 to 2. Argument byte 3 has no effect.
- R9: Opcode 0x81 loads `read_cnt_o` from argument bytes 0 and 1, and `delay_cnt_o` from argument bytes 2 and 3.
- R10: Opcode 0x82 loads `flags_o` from argument bytes 0 and 1. Bytes 2 and 3 have no effect. Channel group g (0 to 3) is enabled, `group_en_o[g]`=1, exactly when flag bit 2+g is 0.
- R11: Any other opcode changes no register and no armed state. This covers unused short codes, 0xC3+4n, and stage opcodes at or beyond STAGES. An unknown long opcode still consumes four argument bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received host byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Decoder can accept a byte |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_ready_i | input | 1 | Transmitter takes reply byte |
| reset_o | output | 1 | One-cycle pulse on a reset command |
| armed_o | output | 1 | Capture armed |
| wr_strobe_o | output | 1 | One-cycle pulse per completed long command |
| wr_opcode_o | output | 8 | Opcode of completed long command |
| wr_arg_o | output | 32 | Argument of completed long command |
| trig_mask_o | output | 32*STAGES | Trigger mask words, stage n at bits 32n+31:32n |
| trig_value_o | output | 32*STAGES | Trigger value words |
| trig_cfg_o | output | 32*STAGES | Trigger configuration words |
| trig_start_o | output | STAGES | Per stage: its match starts capture |
| divider_o | output | 24 | Sample-clock divider |
| read_cnt_o | output | 16 | Read count minus one, in units of four samples |
| delay_cnt_o | output | 16 | Delay count minus one, in units of four samples |
| flags_o | output | 16 | Capture flag word |
| group_en_o | output | 4 | Channel group enables |

## Verification
The assertions watch several invariants on every cycle. Only long opcodes reach the write strobe, and the framer holds a long opcode while it collects arguments. The armed state rises only after an arm command. A reset leaves the flags and the armed state cleared. Unknown long opcodes leave the registers stable. A stalled reply byte holds still. The bench scenarios show the rest: argument byte ordering into each register, the per-stage opcode offsets, the exact four-byte signature under transmit back-pressure, and the receive stall. They also show that a frame broken by a run of zeros completes with zero bytes and then resets cleanly.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET      = 8'h00;
  localparam logic [7:0] OP_ARM        = 8'h01;
  localparam logic [7:0] OP_IDENT      = 8'h02;
  localparam logic [7:0] OP_DIVIDER    = 8'h80;
  localparam logic [7:0] OP_SIZE       = 8'h81;
  localparam logic [7:0] OP_FLAGS      = 8'h82;
  localparam logic [7:0] OP_STAGE_BASE = 8'hC0;
  localparam int         ARG_BYTES     = 4;
  localparam int         ID_BYTES      = 4;
  localparam int         START_BIT     = 27;

  typedef enum logic {FR_OPCODE, FR_ARG} fr_state_e;

  typedef struct packed {
    logic        vld;
    logic        lng;
    logic [7:0]  op;
    logic [31:0] arg;
  } cmd_t;

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    id_byte = 8'h31;
      2'd1:    id_byte = 8'h53;
      2'd2:    id_byte = 8'h4C;
      default: id_byte = 8'h4F;
    endcase
  endfunction
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
  import la_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  output cmd_t       cmd_o
);
  localparam int CW = $clog2(ARG_BYTES);

  fr_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [7:0]      op_q;
  logic [8*(ARG_BYTES-1)-1:0] arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_OPCODE;
      cnt_q   <= '0;
      op_q    <= '0;
      arg_q   <= '0;
      cmd_o   <= '0;
    end else begin
      cmd_o.vld <= 1'b0;
      if (byte_vld_i) begin
        case (state_q)
          FR_OPCODE: begin
            if (byte_i[7]) begin
              op_q    <= byte_i;
              cnt_q   <= '0;
              state_q <= FR_ARG;
            end else begin
              cmd_o <= '{vld: 1'b1, lng: 1'b0, op: byte_i, arg: 32'h0};
            end
          end
          default: begin
            if (cnt_q == CW'(ARG_BYTES - 1)) begin
              cmd_o   <= '{vld: 1'b1, lng: 1'b1, op: op_q, arg: {byte_i, arg_q}};
              state_q <= FR_OPCODE;
            end else begin
              arg_q <= {byte_i, arg_q[8*(ARG_BYTES-1)-1:8]};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_long_opcode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FR_ARG) |-> op_q[7]);
  assert_strobe_is_long_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o.vld && cmd_o.lng) |-> cmd_o.op[7]);
  assert_short_is_short_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o.vld && !cmd_o.lng) |-> !cmd_o.op[7]);
endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
  import la_cmd_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cmd_t                cmd_i,
  output logic                reset_o,
  output logic                armed_o,
  output logic [32*STAGES-1:0] trig_mask_o,
  output logic [32*STAGES-1:0] trig_value_o,
  output logic [32*STAGES-1:0] trig_cfg_o,
  output logic [STAGES-1:0]   trig_start_o,
  output logic [23:0]         divider_o,
  output logic [15:0]         read_cnt_o,
  output logic [15:0]         delay_cnt_o,
  output logic [15:0]         flags_o,
  output logic [3:0]          group_en_o
);
  logic short_hit, long_hit, reset_hit;

  assign short_hit = cmd_i.vld && !cmd_i.lng;
  assign long_hit  = cmd_i.vld && cmd_i.lng;
  assign reset_hit = short_hit && (cmd_i.op == OP_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_o     <= 1'b0;
      armed_o     <= 1'b0;
      divider_o   <= '0;
      read_cnt_o  <= '0;
      delay_cnt_o <= '0;
      flags_o     <= '0;
    end else begin
      reset_o <= reset_hit;
      if (reset_hit) begin
        armed_o <= 1'b0;
        flags_o <= '0;
      end else if (short_hit && cmd_i.op == OP_ARM) begin
        armed_o <= 1'b1;
      end else if (long_hit) begin
        case (cmd_i.op)
          OP_DIVIDER: divider_o <= cmd_i.arg[23:0];
          OP_SIZE: begin
            read_cnt_o  <= cmd_i.arg[15:0];
            delay_cnt_o <= cmd_i.arg[31:16];
          end
          OP_FLAGS: flags_o <= cmd_i.arg[15:0];
          default: ;
        endcase
      end
    end
  end

  assign group_en_o = ~flags_o[5:2];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam logic [7:0] OP_MASK  = OP_STAGE_BASE + 8'(4 * g);
    localparam logic [7:0] OP_VALUE = OP_MASK + 8'd1;
    localparam logic [7:0] OP_CFG   = OP_MASK + 8'd2;
    logic [31:0] mask_q, value_q, cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q  <= '0;
        value_q <= '0;
        cfg_q   <= '0;
      end else if (reset_hit) begin
        mask_q  <= '0;
        value_q <= '0;
        cfg_q   <= '0;
      end else if (long_hit) begin
        if (cmd_i.op == OP_MASK)  mask_q  <= cmd_i.arg;
        if (cmd_i.op == OP_VALUE) value_q <= cmd_i.arg;
        if (cmd_i.op == OP_CFG)   cfg_q   <= cmd_i.arg;
      end
    end

    assign trig_mask_o[32*g +: 32]  = mask_q;
    assign trig_value_o[32*g +: 32] = value_q;
    assign trig_cfg_o[32*g +: 32]   = cfg_q;
    assign trig_start_o[g]          = cfg_q[START_BIT];
  end

  assert_arm_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(cmd_i.vld && !cmd_i.lng && cmd_i.op == OP_ARM));
  assert_reset_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> (flags_o == '0 && !armed_o && trig_start_o == '0));
  assert_unknown_long_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.vld && cmd_i.lng && cmd_i.op[7:4] == 4'h9) |=>
      ($stable(flags_o) && $stable(divider_o) && $stable(read_cnt_o) && $stable(trig_cfg_o)));
endmodule

// File: rtl/la_id_tx.sv
module la_id_tx
  import la_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);
  localparam int IW = $clog2(ID_BYTES);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      idx_q      <= '0;
    end else if (!tx_valid_o) begin
      if (start_i) begin
        tx_valid_o <= 1'b1;
        idx_q      <= '0;
      end
    end else if (tx_ready_i) begin
      if (idx_q == IW'(ID_BYTES - 1)) tx_valid_o <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign tx_data_o = id_byte(2'(idx_q));

  assert_tx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           rx_data_i,
  input  logic                 rx_valid_i,
  output logic                 rx_ready_o,
  output logic [7:0]           tx_data_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic                 reset_o,
  output logic                 armed_o,
  output logic                 wr_strobe_o,
  output logic [7:0]           wr_opcode_o,
  output logic [31:0]          wr_arg_o,
  output logic [32*STAGES-1:0] trig_mask_o,
  output logic [32*STAGES-1:0] trig_value_o,
  output logic [32*STAGES-1:0] trig_cfg_o,
  output logic [STAGES-1:0]    trig_start_o,
  output logic [23:0]          divider_o,
  output logic [15:0]          read_cnt_o,
  output logic [15:0]          delay_cnt_o,
  output logic [15:0]          flags_o,
  output logic [3:0]           group_en_o
);
  cmd_t cmd;
  logic id_start;

  assign id_start   = cmd.vld && !cmd.lng && (cmd.op == OP_IDENT);
  assign rx_ready_o = !tx_valid_o && !id_start;

  la_cmd_framer u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (rx_data_i),
    .byte_vld_i (rx_valid_i && rx_ready_o),
    .cmd_o      (cmd)
  );

  la_cmd_regs #(.STAGES(STAGES)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .reset_o      (reset_o),
    .armed_o      (armed_o),
    .trig_mask_o  (trig_mask_o),
    .trig_value_o (trig_value_o),
    .trig_cfg_o   (trig_cfg_o),
    .trig_start_o (trig_start_o),
    .divider_o    (divider_o),
    .read_cnt_o   (read_cnt_o),
    .delay_cnt_o  (delay_cnt_o),
    .flags_o      (flags_o),
    .group_en_o   (group_en_o)
  );

  la_id_tx u_id_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (id_start),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i)
  );

  assign wr_strobe_o = cmd.vld && cmd.lng;
  assign wr_opcode_o = cmd.op;
  assign wr_arg_o    = cmd.arg;

  assert_rx_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o);
endmodule

// File: tb/la_cmd_decoder_bench.sv
module la_cmd_decoder_bench;
  localparam int STAGES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b1;
  logic reset_p, armed, wr_strobe;
  logic [7:0] wr_opcode;
  logic [31:0] wr_arg;
  logic [32*STAGES-1:0] trig_mask, trig_value, trig_cfg;
  logic [STAGES-1:0] trig_start;
  logic [23:0] divider;
  logic [15:0] read_cnt, delay_cnt, flags;
  logic [3:0] group_en;

  int checks = 0;
  int errors = 0;
  int reset_seen = 0;
  logic [7:0]  q_op[$];
  logic [31:0] q_arg[$];
  logic [7:0]  q_tx[$];

  always #2 clk = ~clk;

  la_cmd_decoder #(.STAGES(STAGES)) u_la_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .reset_o(reset_p), .armed_o(armed),
    .wr_strobe_o(wr_strobe), .wr_opcode_o(wr_opcode), .wr_arg_o(wr_arg),
    .trig_mask_o(trig_mask), .trig_value_o(trig_value), .trig_cfg_o(trig_cfg),
    .trig_start_o(trig_start), .divider_o(divider),
    .read_cnt_o(read_cnt), .delay_cnt_o(delay_cnt),
    .flags_o(flags), .group_en_o(group_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wr_strobe) begin
        if (q_op.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual unexpected strobe %h expected none", wr_opcode);
        end else begin
          check("R2 opcode", {24'h0, wr_opcode}, {24'h0, q_op.pop_front()});
          check("R2 argument", wr_arg, q_arg.pop_front());
        end
      end
      if (rst_n && tx_valid && tx_ready) begin
        if (q_tx.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 actual unexpected byte %h expected none", tx_data);
        end else
          check("R4 reply byte", {24'h0, tx_data}, {24'h0, q_tx.pop_front()});
      end
      if (rst_n && reset_p) reset_seen++;
    end
  end

  // Transmit back-pressure pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      tx_ready = (cyc % 3) != 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    q_op.push_back(op);
    q_arg.push_back(arg);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(arg[8*i +: 8]);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_short(input logic [7:0] op);
    send_byte(op);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R3 reset armed", {31'h0, armed}, 0);
    check("R10 reset flags", {16'h0, flags}, 0);
    check("R10 reset groups", {28'h0, group_en}, 32'hF);
    check("R4 reset rx_ready", {31'h0, rx_ready}, 1);

    // R8: byte 3 ignored
    send_long(8'h80, 32'hAB12_3456);
    check("R8 divider", {8'h0, divider}, 32'h0012_3456);

    // R9
    send_long(8'h81, 32'h0007_00FF);
    check("R9 read count", {16'h0, read_cnt}, 32'h00FF);
    check("R9 delay count", {16'h0, delay_cnt}, 32'h0007);

    // R10: bytes 2,3 ignored; flag bits 2 and 5 disable groups 0 and 3
    send_long(8'h82, 32'hFFFF_0024);
    check("R10 flags", {16'h0, flags}, 32'h0024);
    check("R10 group enables", {28'h0, group_en}, 32'h6);

    // R6, R7: per-stage opcodes at offset 4n
    for (int n = 0; n < STAGES; n++) begin
      send_long(8'hC0 + 8'(4*n), 32'h1111_1111 * (n + 1));
      send_long(8'hC1 + 8'(4*n), 32'hA0A0_0000 + 32'(n));
      send_long(8'hC2 + 8'(4*n), {(n == STAGES-1) ? 8'h08 : 8'h00, 8'(n), 16'h0});
    end
    for (int n = 0; n < STAGES; n++) begin
      check("R6 stage mask", trig_mask[32*n +: 32], 32'h1111_1111 * (n + 1));
      check("R6 stage value", trig_value[32*n +: 32], 32'hA0A0_0000 + 32'(n));
      check("R7 stage number", {24'h0, trig_cfg[32*n+16 +: 8]}, 32'(n));
    end
    check("R7 start stage", {28'h0, trig_start}, 32'h8);

    // R5
    send_short(8'h01);
    check("R5 armed", {31'h0, armed}, 1);

    // R4: identify under back-pressure, receive stalled meanwhile
    q_tx.push_back(8'h31); q_tx.push_back(8'h53);
    q_tx.push_back(8'h4C); q_tx.push_back(8'h4F);
    send_byte(8'h02);
    check("R4 rx stalled during reply", {31'h0, rx_ready}, 0);
    repeat (20) @(negedge clk);
    check("R4 reply drained", q_tx.size(), 0);
    check("R4 rx ready after reply", {31'h0, rx_ready}, 1);

    // R11: unknown opcodes leave state alone; R1: unknown long eats 4 bytes
    send_short(8'h07);
    send_long(8'h90, 32'hFFFF_FFFF);
    send_long(8'hC3, 32'hFFFF_FFFF);
    send_long(8'hC0 + 8'(4*STAGES), 32'hFFFF_FFFF);
    check("R11 flags kept", {16'h0, flags}, 32'h0024);
    check("R11 divider kept", {8'h0, divider}, 32'h0012_3456);
    check("R11 armed kept", {31'h0, armed}, 1);
    check("R11 stage0 mask kept", trig_mask[31:0], 32'h1111_1111);
    check("R11 start kept", {28'h0, trig_start}, 32'h8);

    // R3: break a flag command with five zeros
    reset_seen = 0;
    q_op.push_back(8'h82);
    q_arg.push_back(32'h0000_5555);
    send_byte(8'h82);
    send_byte(8'h55);
    send_byte(8'h55);
    for (int i = 0; i < 5; i++) send_byte(8'h00);
    repeat (3) @(negedge clk);
    check("R3 reset pulses", reset_seen, 3);
    check("R3 flags cleared", {16'h0, flags}, 0);
    check("R3 armed cleared", {31'h0, armed}, 0);
    check("R3 masks cleared", trig_mask[31:0] | trig_mask[127:96], 0);
    check("R3 cfg cleared", trig_cfg[127:96], 0);
    check("R3 divider kept", {8'h0, divider}, 32'h0012_3456);
    check("R3 read count kept", {16'h0, read_cnt}, 32'h00FF);

    // R1: framing restored
    send_short(8'h01);
    check("R1 short after resync", {31'h0, armed}, 1);
    send_long(8'h82, 32'h0000_0004);
    check("R1 long after resync", {28'h0, group_en}, 32'hE);
    check("R2 scoreboard drained", q_op.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule